// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block sends bytes, or 9-bit words, over a two-wire synchronous link. It generates the shift clock itself and drives both the clock and the data line. Software writes a word into a single holding register. When the transmitter is enabled, the shifter is idle and no receive request is pending, the word moves into an internal shift register in one system clock. The word is then sent least significant bit first. Each new bit is placed on the data line as the shift clock rises, so the data is steady when the clock falls.

The clock and the data line each have their own output enable, so that a pad can tri-state them. When transmit enable drops, the block aborts the word in progress, resets the transmitter and releases both lines. A receive request (continuous or single-word) works differently. It releases only the data line. The clock stays driven when the internal clock source is selected, and the word in progress is held frozen. When the request is removed, transmission resumes and the data line is driven again at once. Two flags report the state of the two registers: one says the holding register is free, the other says the shifter is free.

Top module: `sync_master_tx`

## Requirements
- R1: After reset, hold_empty and shift_empty are 1, sck_o and sdo_o are 0, and sck_oe and sdo_oe are 0.
- R2: A write (wr_en=1) clears hold_empty on the next clock. A transfer into the shifter is the only event that sets hold_empty again. The transfer happens on the first clock where the shifter is free, tx_enable is 1, neither receive request is set and the holding register is full.
- R3: The shift clock has a period of exactly 4*(divisor+1) system clocks. Its divider is held at zero while tx_enable, rx_cont and rx_single are all 0. The divider starts counting on the first clock where any of them is 1.
- R4: Bits leave least significant first. sdo_o changes on the same clock where sck_o rises and keeps its value for the whole high half of the shift clock. Outside a word, the driven shift clock rests low.
- R5: With mode9=1, a word has 9 bits and the ninth bit comes after bit 7. Its value is bit9_in as sampled on the clock of the transfer. A later change of bit9_in does not affect a word already transferred.
- R6: If a second word is waiting when the last bit of the current word ends, it is transferred on that same clock. Its first bit goes out on the very next rising edge of the shift clock, and shift_empty stays 0 throughout.
- R7: A word written while tx_enable=0 stays in the holding register and shift_empty stays 1. The word is transferred on the first clock after tx_enable is set.
- R8: When tx_enable is 0 and no receive request is set, sck_oe and sdo_oe are 0 in the same cycle. One clock later shift_empty is 1 and sck_o and sdo_o are 0, and the word in progress is lost.
- R9: While rx_cont or rx_single is set, sdo_oe is 0 and the state of the transmitter is frozen. When the request clears and tx_enable is still 1, sdo_oe returns to 1 in the same cycle and the frozen word continues.
- R10: sck_oe is 1 exactly when clk_src_int is 1 and at least one of tx_enable, rx_cont or rx_single is 1. While a receive request is set, sck_o follows the free-running divider phase.
- R11: shift_empty is 0 from the transfer until the falling edge of the shift clock that ends the last bit of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word written into the holding register |
| bit9_in | input | 1 | Ninth bit, sampled on the transfer |
| mode9 | input | 1 | 1 selects 9-bit words |
| tx_enable | input | 1 | Transmit enable; clearing it aborts the word |
| clk_src_int | input | 1 | 1 makes this block drive the shift clock |
| rx_cont | input | 1 | Continuous receive request |
| rx_single | input | 1 | Single-word receive request |
| divisor | input | 8 | Shift clock divisor; period is 4*(divisor+1) |
| sck_o | output | 1 | Shift clock value |
| sck_oe | output | 1 | Shift clock output enable |
| sdo_o | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data output enable |
| hold_empty | output | 1 | Holding register is free |
| shift_empty | output | 1 | Shift register is free |

## Verification
The assertions assume that divisor and mode9 stay constant while a word is in the shifter, and that a write never replaces a word still waiting in a full holding register. Under those assumptions, the stability and freeze properties are exact statements about clock edges. The stimulus changes divisor and mode9 only after both flags report empty. It issues each write only when the holding register is free, or when the write is the deliberate second word of a back-to-back pair. Receive requests are raised and cleared in the middle of a word, so that the freeze and the resume are exercised in that state.

// File: rtl/sync_master_tx.sv
module sync_master_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9_in,
  input  logic              mode9,
  input  logic              tx_enable,
  input  logic              clk_src_int,
  input  logic              rx_cont,
  input  logic              rx_single,
  input  logic [DIV_W-1:0]  divisor,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              sdo_o,
  output logic              sdo_oe,
  output logic              hold_empty,
  output logic              shift_empty
);
  localparam int SW = DATA_W + 1;
  localparam int BW = $clog2(DATA_W + 2);
  localparam logic [BW-1:0] LEN_N = BW'(DATA_W);
  localparam logic [BW-1:0] LEN_X = BW'(DATA_W + 1);

  logic              rx_req, div_run, tick, rise, fall, last_done, load;
  logic              phase, busy, sck_q, sdo_q;
  logic [DIV_W:0]    cnt;
  logic [DATA_W-1:0] hold_q;
  logic [SW-1:0]     shreg;
  logic [BW-1:0]     bits_left;

  assign rx_req    = rx_cont | rx_single;
  assign div_run   = tx_enable | rx_req;
  assign tick      = div_run && (cnt == {divisor, 1'b1});
  assign rise      = tick && !phase;
  assign fall      = tick && phase;
  assign last_done = busy && fall && (bits_left == '0);
  assign load      = tx_enable && !rx_req && !hold_empty && (!busy || last_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!div_run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_empty <= 1'b1;
    end else if (wr_en) begin
      hold_q     <= wr_data;
      hold_empty <= 1'b0;
    end else if (load) begin
      hold_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bits_left <= '0;
      shreg     <= '0;
      sck_q     <= 1'b0;
      sdo_q     <= 1'b0;
    end else if (!tx_enable) begin
      busy      <= 1'b0;
      bits_left <= '0;
      sck_q     <= 1'b0;
      sdo_q     <= 1'b0;
    end else if (!rx_req) begin
      if (busy && rise && bits_left != '0) begin
        sdo_q     <= shreg[0];
        shreg     <= shreg >> 1;
        bits_left <= bits_left - 1'b1;
        sck_q     <= 1'b1;
      end
      if (fall) sck_q <= 1'b0;
      if (load) begin
        busy      <= 1'b1;
        shreg     <= {bit9_in, hold_q};
        bits_left <= mode9 ? LEN_X : LEN_N;
      end else if (last_done) begin
        busy      <= 1'b0;
      end
    end
  end

  assign sck_o       = rx_req ? phase : sck_q;
  assign sck_oe      = clk_src_int & div_run;
  assign sdo_o       = sdo_q;
  assign sdo_oe      = tx_enable & ~rx_req;
  assign shift_empty = ~busy;

  assert_hold_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);

  assert_hold_set_by_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> !shift_empty);

  assert_divider_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !div_run |=> (cnt == '0 && !phase));

  assert_data_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(sdo_q));

  assert_word_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= LEN_X);

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> (shift_empty && !sck_q && !sdo_q));

  assert_frozen_on_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && tx_enable) |=> ($stable(shreg) && $stable(bits_left) && $stable(busy)));

  assert_shifter_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> !sck_q || !tx_enable);
endmodule

// File: tb/sync_master_tx_tb.sv
module sync_master_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, bit9_in = 0, mode9 = 0, tx_enable = 0, clk_src_int = 1, rx_cont = 0, rx_single = 0;
  logic [7:0] wr_data = 0, divisor = 0;
  logic sck_o, sck_oe, sdo_o, sdo_oe, hold_empty, shift_empty;

  always #4 clk = ~clk;

  sync_master_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .bit9_in(bit9_in),
    .mode9(mode9), .tx_enable(tx_enable), .clk_src_int(clk_src_int), .rx_cont(rx_cont),
    .rx_single(rx_single), .divisor(divisor), .sck_o(sck_o), .sck_oe(sck_oe), .sdo_o(sdo_o),
    .sdo_oe(sdo_oe), .hold_empty(hold_empty), .shift_empty(shift_empty));

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;

  int  m_cnt = 0;
  bit  m_phase = 0, m_busy = 0, m_sckq = 0, m_sdoq = 0, m_hem = 1;
  bit  m_q[$];
  logic [7:0] m_hold = 0;

  bit  rxq[$];
  int  rise_cyc[$];
  bit  prev_cap = 0, prev_se = 1;
  int  se_rises = 0;

  task automatic chk(string tag, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%b exp=%b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_busy = 0; m_sckq = 0; m_sdoq = 0; m_hem = 1; m_hold = 0;
      m_q.delete();
    end else begin
      bit rxr, run, tk, up, dn, endw, ld;
      bit [8:0] word;
      int half;
      half = 2 * (int'(divisor) + 1);
      rxr  = rx_cont | rx_single;
      run  = tx_enable | rxr;
      tk   = run && (m_cnt == half - 1);
      up   = tk && !m_phase;
      dn   = tk && m_phase;
      endw = m_busy && dn && (m_q.size() == 0);
      ld   = tx_enable && !rxr && !m_hem && (!m_busy || endw);
      word = {bit9_in, m_hold};
      if (!tx_enable) begin
        m_busy = 0; m_q.delete(); m_sckq = 0; m_sdoq = 0;
      end else if (!rxr) begin
        if (m_busy && up && m_q.size() > 0) begin
          m_sdoq = m_q.pop_front();
          m_sckq = 1;
        end
        if (dn) m_sckq = 0;
        if (ld) begin
          m_busy = 1;
          m_q.delete();
          for (int i = 0; i < (mode9 ? 9 : 8); i++) m_q.push_back(word[i]);
        end else if (endw) m_busy = 0;
      end
      if (wr_en) begin m_hold = wr_data; m_hem = 0; end
      else if (ld) m_hem = 1;
      if (!run) begin m_cnt = 0; m_phase = 0; end
      else if (tk) begin m_cnt = 0; m_phase = ~m_phase; end
      else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit rxr, cap;
      rxr = rx_cont | rx_single;
      chk("R10 sck_o",       sck_o,       rxr ? m_phase : m_sckq);
      chk("R10 sck_oe",      sck_oe,      clk_src_int & (tx_enable | rxr));
      chk("R4 sdo_o",        sdo_o,       m_sdoq);
      chk("R9 sdo_oe",       sdo_oe,      tx_enable & !rxr);
      chk("R2 hold_empty",   hold_empty,  m_hem);
      chk("R11 shift_empty", shift_empty, !m_busy);
      cap = sck_o & sck_oe & sdo_oe;
      if (cap && !prev_cap) begin rxq.push_back(sdo_o); rise_cyc.push_back(cyc); end
      prev_cap = cap;
      if (shift_empty && !prev_se) se_rises++;
      prev_se = shift_empty;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic write(logic [7:0] d);
    wr_data = d; wr_en = 1; step(); wr_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (hold_empty && shift_empty) break;
    end
    step();
  endtask

  task automatic clear_capture();
    rxq.delete(); rise_cyc.delete(); se_rises = 0;
  endtask

  task automatic chk_stream(string tag, logic [8:0] w0, int n0, logic [8:0] w1, int n1);
    bit ok;
    ok = (rxq.size() == n0 + n1);
    for (int i = 0; ok && i < n0; i++) if (rxq[i] != w0[i]) ok = 0;
    for (int i = 0; ok && i < n1; i++) if (rxq[n0+i] != w1[i]) ok = 0;
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s got=%0d bits exp=%0d bits (or bit order mismatch)", tag, rxq.size(), n0 + n1);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  initial begin
    step(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 hold_empty", hold_empty, 1); chk("R1 shift_empty", shift_empty, 1);
    chk("R1 sck_oe", sck_oe, 0); chk("R1 sdo_oe", sdo_oe, 0); chk("R1 sck_o", sck_o, 0);
    step();

    divisor = 1; clear_capture();
    write(8'hA5);
    step(20);
    @(negedge clk);
    chk("R7 held while disabled", hold_empty, 0);
    chk("R7 shifter idle while disabled", shift_empty, 1);
    step(); tx_enable = 1; step(2);
    @(negedge clk);
    chk("R7 transfer on enable", hold_empty, 1);
    chk("R2 shifter loaded", shift_empty, 0);
    step(); write(8'h3C);
    wait_idle();
    chk_stream("R6 back-to-back A5,3C", 9'h0A5, 8, 9'h03C, 8);
    chk("R6 no gap between words", se_rises == 1, 1);
    chk("R3 period div=1", (rise_cyc.size() > 1) && (rise_cyc[1] - rise_cyc[0] == 8), 1);

    divisor = 0; mode9 = 1; bit9_in = 1; clear_capture();
    write(8'h0F);
    wait_idle();
    chk_stream("R5 ninth bit one", 9'h10F, 9, 9'h0, 0);
    chk("R3 period div=0", (rise_cyc.size() > 1) && (rise_cyc[1] - rise_cyc[0] == 4), 1);

    clear_capture(); bit9_in = 0;
    write(8'h81); step(2); bit9_in = 1;
    wait_idle();
    chk_stream("R5 ninth sampled at transfer", 9'h081, 9, 9'h0, 0);

    mode9 = 0; divisor = 2;
    write(8'hFF); step(10);
    tx_enable = 0;
    @(negedge clk);
    chk("R8 sdo_oe released", sdo_oe, 0);
    chk("R8 sck_oe released", sck_oe, 0);
    step();
    @(negedge clk);
    chk("R8 shifter reset", shift_empty, 1);
    chk("R8 data low", sdo_o, 0);
    step(5);

    tx_enable = 1; step();
    write(8'h5A); step(15);
    rx_single = 1;
    @(negedge clk);
    chk("R9 data released on rx", sdo_oe, 0);
    chk("R10 clock kept on rx", sck_oe, 1);
    step(30);
    rx_single = 0;
    @(negedge clk);
    chk("R9 data driven on release", sdo_oe, 1);
    chk("R9 word still pending", shift_empty, 0);
    step(7); rx_cont = 1; step(12); rx_cont = 0;
    wait_idle();
    chk("R9 word completes", shift_empty && hold_empty, 1);

    clk_src_int = 0;
    write(8'h33); step(5);
    @(negedge clk);
    chk("R10 external clock not driven", sck_oe, 0);
    wait_idle();

    tx_enable = 0; step(4);
    summary();
  end
endmodule